// File: doc/BRIEF.md
# Match-Driven Watchdog Timer

This block is a watchdog timer with a small 32-bit register bus. Software writes the registers through an address, a write strobe and write data. It reads them back combinationally through a read strobe. A 32-bit up-counter runs while it is enabled and is compared with a programmable match value. When the running counter equals the match value, a hit occurs. A hit can do any of the following: latch an interrupt, stop the counter, clear the counter, update an external match pin, and launch a timed reset pulse on an internal or an external reset line.

A debug-halt input can freeze the counter. A sticky status bit records that a watchdog pulse was issued. That bit and the pulse generator are reset only by the power-on reset input. As a result, a pulse that loops back into the general reset still runs to its full length, and the cause can still be read after the restart.

Top module: `mwd_top`

## Requirements
- R1: After reset, every register reads zero, and irqOut, matchPin, intRstOut and extRstOut are low.
- R2: With control bit 0 set and control bit 1 clear at offset 0x04, the counter at 0x08 rises by one each clock. Writing 0 to the control register freezes the counter at its current value.
- R3: While control bit 1 is set, the counter reads zero and does not advance. The control register reads back the value written.
- R4: While control bit 2 and dbgHalt are both high, the counter holds its value. With control bit 2 clear, dbgHalt has no effect.
- R5: A hit occurs when the counter runs and equals the match value at 0x10. If match-control bit 0 at 0x0C is set, a hit sets the pending bit 0 of 0x00, and irqOut follows it. Writing 1 to that bit clears it. If a hit and a clear fall in the same cycle, the bit stays set.
- R6: If match-control bit 2 is set, a hit leaves the counter at the match value and clears control bit 0.
- R7: If match-control bit 1 is set, the counter reads zero in the cycle after a hit.
- R8: Bit 0 at 0x14 drives matchPin. The field at bits 5:4 is the action taken on a hit: 0 none, 1 drive low, 2 drive high, 3 toggle. A hit action wins over a same-cycle write of bit 0.
- R9: A hit with match-control bit 3 or bit 4 set raises intRstOut or extRstOut respectively. The pulse lasts the 16-bit value at 0x18 plus 6 cycles. A trigger that arrives during a pulse is ignored.
- R10: Writing 1 to match-control bit 5 or bit 6 starts an internal or external pulse at once. Both bits read back zero.
- R11: Bit 0 at 0x1C sets when a pulse starts and ignores writes. That bit and a running pulse survive rstN, and only porN clears them.
- R12: Reads of unmapped offsets return zero, and busRdData is zero while busRdEn is low. Writes to the counter offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rstN | input | 1 | General asynchronous reset, active low |
| porN | input | 1 | Power-on reset, active low; also clears status and pulse |
| busAddr | input | 8 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, combinational |
| dbgHalt | input | 1 | Debugger halt request |
| irqOut | output | 1 | Pending match interrupt |
| matchPin | output | 1 | External match output |
| intRstOut | output | 1 | Internal reset pulse |
| extRstOut | output | 1 | External reset pulse |

## Verification
A hit can land in the same clock edge as a software write that touches the same state. Two collisions are provoked on purpose. In the first, the bench writes 1 to the interrupt-clear bit in exactly the cycle the counter sits on the match value. In the second, it rewrites the match-pin bit in that same cycle. The bench counts cycles from the enable write so that the write edge and the hit edge coincide. It then judges each collision by R5 and R8: the set wins, and the hit action wins. A third collision, a forced pulse during a running pulse, must leave the second reset line untouched.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int unsigned OFF_INT   = 32'h00;
  localparam int unsigned OFF_CTRL  = 32'h04;
  localparam int unsigned OFF_CNT   = 32'h08;
  localparam int unsigned OFF_MCTRL = 32'h0C;
  localparam int unsigned OFF_MATCH = 32'h10;
  localparam int unsigned OFF_EMR   = 32'h14;
  localparam int unsigned OFF_PULSE = 32'h18;
  localparam int unsigned OFF_RSTAT = 32'h1C;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } pinAct_t;

  // strobes from control to datapath
  typedef struct packed {
    logic countRun;
    logic countHold;
    logic clearOnHit;
    logic stopOnHit;
    logic pulseGo;
    logic pulseInt;
    logic pulseExt;
  } dpCmd_t;
endpackage

// File: rtl/mwd_dpath.sv
module mwd_dpath
  import mwd_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int LEN_W       = 16,
  parameter int PULSE_EXTRA = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] matchVal,
  input  logic [LEN_W-1:0] pulseLen,
  output logic [CNT_W-1:0] count,
  output logic             hit,
  output logic             pulseBusy,
  output logic             intRstOut,
  output logic             extRstOut
);
  localparam int REM_W   = LEN_W + 1;
  localparam int N_CHAN  = 2;

  logic [REM_W-1:0]  remain;
  logic [N_CHAN-1:0] chanReq;
  logic [N_CHAN-1:0] chanOn;

  assign hit = cmd.countRun && !cmd.countHold && (count == matchVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (cmd.countHold) begin
      count <= '0;
    end else if (hit && cmd.clearOnHit) begin
      count <= '0;
    end else if (hit && cmd.stopOnHit) begin
      count <= count;
    end else if (cmd.countRun) begin
      count <= count + 1'b1;
    end
  end

  // pulse timer lives in the power-on domain so a pulse outlasts rstN
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pulseBusy <= 1'b0;
      remain    <= '0;
    end else if (cmd.pulseGo) begin
      pulseBusy <= 1'b1;
      remain    <= REM_W'(pulseLen) + REM_W'(PULSE_EXTRA - 1);
    end else if (pulseBusy) begin
      if (remain == '0) pulseBusy <= 1'b0;
      else              remain    <= remain - 1'b1;
    end
  end

  assign chanReq = {cmd.pulseExt, cmd.pulseInt};

  for (genvar ch = 0; ch < N_CHAN; ch++) begin : gChan
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)                          chanOn[ch] <= 1'b0;
      else if (cmd.pulseGo)               chanOn[ch] <= chanReq[ch];
      else if (pulseBusy && remain == '0) chanOn[ch] <= 1'b0;
    end
  end

  assign intRstOut = pulseBusy && chanOn[0];
  assign extRstOut = pulseBusy && chanOn[1];

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cmd.countHold |=> (count == '0)); // R3
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.countRun && !cmd.countHold) |=> $stable(count)); // R4
  AST_CLEAR_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (hit && cmd.clearOnHit) |=> (count == '0)); // R7
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (hit && cmd.stopOnHit && !cmd.clearOnHit) |=> $stable(count)); // R6
endmodule

// File: rtl/mwd_ctrl.sv
module mwd_ctrl
  import mwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              dbgHalt,
  input  logic [DATA_W-1:0] count,
  input  logic              hit,
  input  logic              pulseBusy,
  output dpCmd_t            cmd,
  output logic [DATA_W-1:0] matchVal,
  output logic [LEN_W-1:0]  pulseLen,
  output logic              irqOut,
  output logic              matchPin
);
  logic [2:0] ctrlReg;
  logic [4:0] mctrlReg;
  pinAct_t    emrAct;
  logic       emrPin;
  logic       intPend;
  logic       rstStat;

  logic wrInt, wrCtrl, wrMctrl, wrMatch, wrEmr, wrPulse;
  logic goInt, goExt;

  assign wrInt   = busWrEn && (busAddr == ADDR_W'(OFF_INT));
  assign wrCtrl  = busWrEn && (busAddr == ADDR_W'(OFF_CTRL));
  assign wrMctrl = busWrEn && (busAddr == ADDR_W'(OFF_MCTRL));
  assign wrMatch = busWrEn && (busAddr == ADDR_W'(OFF_MATCH));
  assign wrEmr   = busWrEn && (busAddr == ADDR_W'(OFF_EMR));
  assign wrPulse = busWrEn && (busAddr == ADDR_W'(OFF_PULSE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrCtrl) begin
      ctrlReg <= busWrData[2:0];
    end else if (hit && mctrlReg[2]) begin
      ctrlReg[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mctrlReg <= '0;
      matchVal <= '0;
      pulseLen <= '0;
      emrAct   <= ACT_NONE;
    end else begin
      if (wrMctrl) mctrlReg <= busWrData[4:0];
      if (wrMatch) matchVal <= busWrData;
      if (wrPulse) pulseLen <= busWrData[LEN_W-1:0];
      if (wrEmr)   emrAct   <= pinAct_t'(busWrData[5:4]);
    end
  end

  // interrupt: a hit outranks a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      intPend <= 1'b0;
    else if (hit && mctrlReg[0])    intPend <= 1'b1;
    else if (wrInt && busWrData[0]) intPend <= 1'b0;
  end

  // external pin: the hit action outranks a same-cycle write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emrPin <= 1'b0;
    end else if (hit && emrAct != ACT_NONE) begin
      unique case (emrAct)
        ACT_LOW:    emrPin <= 1'b0;
        ACT_HIGH:   emrPin <= 1'b1;
        ACT_TOGGLE: emrPin <= !emrPin;
        default:    emrPin <= emrPin;
      endcase
    end else if (wrEmr) begin
      emrPin <= busWrData[0];
    end
  end

  assign goInt = (hit && mctrlReg[3]) || (wrMctrl && busWrData[5]);
  assign goExt = (hit && mctrlReg[4]) || (wrMctrl && busWrData[6]);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)            rstStat <= 1'b0;
    else if (cmd.pulseGo) rstStat <= 1'b1;
  end

  always_comb begin
    cmd.countRun   = ctrlReg[0] && !(ctrlReg[2] && dbgHalt);
    cmd.countHold  = ctrlReg[1];
    cmd.clearOnHit = mctrlReg[1];
    cmd.stopOnHit  = mctrlReg[2];
    cmd.pulseGo    = (goInt || goExt) && !pulseBusy;
    cmd.pulseInt   = goInt;
    cmd.pulseExt   = goExt;
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      unique case (busAddr)
        ADDR_W'(OFF_INT):   busRdData = DATA_W'(intPend);
        ADDR_W'(OFF_CTRL):  busRdData = DATA_W'(ctrlReg);
        ADDR_W'(OFF_CNT):   busRdData = count;
        ADDR_W'(OFF_MCTRL): busRdData = DATA_W'(mctrlReg);
        ADDR_W'(OFF_MATCH): busRdData = matchVal;
        ADDR_W'(OFF_EMR):   busRdData = DATA_W'({emrAct, 3'b000, emrPin});
        ADDR_W'(OFF_PULSE): busRdData = DATA_W'(pulseLen);
        ADDR_W'(OFF_RSTAT): busRdData = DATA_W'(rstStat);
        default:            busRdData = '0;
      endcase
    end
  end

  assign irqOut   = intPend;
  assign matchPin = emrPin;

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    (hit && mctrlReg[0]) |=> irqOut); // R5
  AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (hit && mctrlReg[2] && !wrCtrl) |=> !ctrlReg[0]); // R6
  AST_PIN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (hit && emrAct == ACT_HIGH) |=> matchPin); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!porN)
    rstStat |=> rstStat); // R11
endmodule

// File: rtl/mwd_top.sv
module mwd_top
  import mwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              dbgHalt,
  output logic              irqOut,
  output logic              matchPin,
  output logic              intRstOut,
  output logic              extRstOut
);
  dpCmd_t            cmd;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] matchVal;
  logic [LEN_W-1:0]  pulseLen;
  logic              hit;
  logic              pulseBusy;

  mwd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .porN(porN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData), .dbgHalt(dbgHalt),
    .count(count), .hit(hit), .pulseBusy(pulseBusy),
    .cmd(cmd), .matchVal(matchVal), .pulseLen(pulseLen),
    .irqOut(irqOut), .matchPin(matchPin)
  );

  mwd_dpath #(.CNT_W(DATA_W), .LEN_W(LEN_W), .PULSE_EXTRA(6)) uDpath (
    .clk(clk), .rstN(rstN), .porN(porN),
    .cmd(cmd), .matchVal(matchVal), .pulseLen(pulseLen),
    .count(count), .hit(hit), .pulseBusy(pulseBusy),
    .intRstOut(intRstOut), .extRstOut(extRstOut)
  );
endmodule

// File: tb/sim_mwd_top.sv
module sim_mwd_top;
  logic        clk = 1'b0;
  logic        rstN, porN, busWrEn, busRdEn, dbgHalt;
  logic [7:0]  busAddr;
  logic [31:0] busWrData, busRdData;
  logic        irqOut, matchPin, intRstOut, extRstOut;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  always #10 clk = !clk;

  mwd_top u0 (
    .clk(clk), .rstN(rstN), .porN(porN), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn),
    .busRdData(busRdData), .dbgHalt(dbgHalt), .irqOut(irqOut),
    .matchPin(matchPin), .intRstOut(intRstOut), .extRstOut(extRstOut)
  );

  localparam logic [7:0] A_INT = 8'h00, A_CTRL = 8'h04, A_CNT = 8'h08,
    A_MCTRL = 8'h0C, A_MATCH = 8'h10, A_EMR = 8'h14, A_PULSE = 8'h18,
    A_RSTAT = 8'h1C;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  // leaves the counter at zero and running at a negedge
  task automatic arm(input logic [31:0] m, input logic [31:0] mc);
    wr(A_CTRL, 32'h2);
    wr(A_MATCH, m);
    wr(A_MCTRL, mc);
    wr(A_CTRL, 32'h1);
  endtask

  function automatic logic expPin(input logic [1:0] act, input logic init);
    case (act)
      2'd0: return init;
      2'd1: return 1'b0;
      2'd2: return 1'b1;
      default: return !init;
    endcase
  endfunction

  function automatic logic [31:0] expCount(input int mode, input logic [31:0] m);
    case (mode)
      1: return m;
      2: return 32'd0;
      default: return m + 32'd1;
    endcase
  endfunction

  function automatic logic [31:0] modeMctrl(input int mode);
    return 32'h1 | (mode == 1 ? 32'h4 : 32'h0) | (mode == 2 ? 32'h2 : 32'h0);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    bit sawExt;
    void'($urandom(32'd4711));
    rstN = 0; porN = 0; busWrEn = 0; busRdEn = 0; dbgHalt = 0;
    busAddr = '0; busWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1; porN = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(8'(a * 4), d); check("R1 reg", d, 32'h0);
    end
    check("R1 outs", {28'h0, irqOut, matchPin, intRstOut, extRstOut}, 32'h0);

    // R4 debug pause
    wr(A_CTRL, 32'h2); wr(A_CTRL, 32'h5);
    dbgHalt = 1; step(10);
    rd(A_CNT, d); check("R4 paused", d, 32'd0);
    dbgHalt = 0; step(4);
    rd(A_CNT, d); check("R4 resumed", d, 32'd4);
    wr(A_CTRL, 32'h1);
    dbgHalt = 1; step(3);
    rd(A_CNT, d); check("R4 pause off", d, 32'd8);
    dbgHalt = 0;

    // R2 stop by writing zero
    wr(A_CTRL, 32'h0); step(5);
    rd(A_CNT, d); check("R2 frozen", d, 32'd9);

    // R12 counter write ignored, unmapped and idle reads
    wr(A_CNT, 32'h55);
    rd(A_CNT, d); check("R12 cnt write", d, 32'd9);
    rd(8'h20, d); check("R12 unmapped", d, 32'h0);
    rd(8'h05, d); check("R12 unaligned", d, 32'h0);
    busAddr = A_CTRL; busRdEn = 0; #1 check("R12 idle read", busRdData, 32'h0);

    // R3 hold at zero
    wr(A_CTRL, 32'h3); step(6);
    rd(A_CNT, d); check("R3 hold", d, 32'd0);
    rd(A_CTRL, d); check("R3 ctrl readback", d, 32'h3);

    // random matches: R2 R5 R6 R7 R8
    for (int i = 0; i < 24; i++) begin
      int mode = $urandom % 3;
      logic [31:0] m = 32'd5 + ($urandom % 60);
      logic [1:0] act = 2'($urandom % 4);
      logic init = 1'($urandom % 2);
      wr(A_EMR, {26'h0, act, 3'b000, init});
      arm(m, modeMctrl(mode));
      step(32'(m));
      rd(A_CNT, d); check("R2 count to match", d, m);
      check("R5 no irq early", {31'h0, irqOut}, 32'h0);
      step(1);
      rd(A_CNT, d);
      if (mode == 1) check("R6 stop count", d, expCount(mode, m));
      else if (mode == 2) check("R7 clear count", d, expCount(mode, m));
      else check("R2 past match", d, expCount(mode, m));
      rd(A_CTRL, d); check("R6 enable bit", d, (mode == 1) ? 32'h0 : 32'h1);
      check("R5 irq set", {31'h0, irqOut}, 32'h1);
      check("R8 pin action", {31'h0, matchPin}, {31'h0, expPin(act, init)});
      wr(A_INT, 32'h1);
      rd(A_INT, d); check("R5 irq clear", d, 32'h0);
    end

    // R5 collision: set and clear in one cycle
    wr(A_EMR, 32'h0);
    arm(32'd8, 32'h1); step(9);
    check("R5 pending before", {31'h0, irqOut}, 32'h1);
    arm(32'd8, 32'h1); step(8);
    wr(A_INT, 32'h1);
    rd(A_INT, d); check("R5 set wins", d, 32'h1);
    wr(A_INT, 32'h1);
    rd(A_INT, d); check("R5 later clear", d, 32'h0);

    // R8 collision: hit action beats write
    wr(A_EMR, 32'h20);
    arm(32'd6, 32'h0); step(6);
    wr(A_EMR, 32'h20);
    check("R8 hit beats write", {31'h0, matchPin}, 32'h1);
    rd(A_EMR, d); check("R8 readback", d, 32'h21);
    wr(A_EMR, 32'h0);

    // R9 pulse on match, retrigger ignored
    wr(A_PULSE, 32'd3);
    arm(32'd7, 32'h8); step(8);
    n = 0; sawExt = 0;
    while (intRstOut && n < 200) begin
      n++;
      if (n == 2) wr(A_MCTRL, 32'h48); else step(1);
      if (extRstOut) sawExt = 1;
    end
    check("R9 pulse width", n, 32'd9);
    check("R9 retrigger ignored", {31'h0, sawExt}, 32'h0);
    rd(A_RSTAT, d); check("R11 status set", d, 32'h1);

    // R10 forced external pulse
    wr(A_CTRL, 32'h0);
    wr(A_PULSE, 32'd0);
    wr(A_MCTRL, 32'h40);
    check("R10 int low", {31'h0, intRstOut}, 32'h0);
    n = 0;
    while (extRstOut && n < 200) begin n++; step(1); end
    check("R10 forced width", n, 32'd6);
    rd(A_MCTRL, d); check("R10 force bits read zero", d, 32'h0);

    // R11 pulse and status survive rstN, cleared by porN
    wr(A_PULSE, 32'd40);
    wr(A_MCTRL, 32'h20);
    step(3);
    rstN = 0; step(2); rstN = 1; step(1);
    check("R11 pulse survives", {31'h0, intRstOut}, 32'h1);
    rd(A_RSTAT, d); check("R11 status survives", d, 32'h1);
    rd(A_PULSE, d); check("R1 rstN clears regs", d, 32'h0);
    wr(A_RSTAT, 32'h0);
    rd(A_RSTAT, d); check("R11 write ignored", d, 32'h1);
    step(50);
    check("R11 pulse ended", {31'h0, intRstOut}, 32'h0);
    porN = 0; step(1); porN = 1; step(1);
    rd(A_RSTAT, d); check("R11 por clears", d, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule